// File: doc/BRIEF.md
# Seven-Bit Packed Sample Stream Decoder

This block sits behind a byte-wide serial receiver and turns a stream of 11-byte packets into parallel sample words. Each packet carries six 10-bit samples, a 6-bit running packet counter and an 8-bit auxiliary value. Seven payload bits are carried per byte. The only alignment cue is bit 7: it is set on the last byte of a packet and clear on every other byte. The decoder works out where each byte sits in the packet from that marker alone. It presents a decoded packet on registered outputs together with a one-cycle valid pulse.

Malformed traffic is reported, and the decoder recovers from it without outside help. A marker that arrives too early aborts the partial packet but keeps alignment. A packet whose last byte lacks the marker sends the decoder back to searching. A nonzero reserved bit in a shared byte is flagged, but the packet is still delivered. A break in the counter sequence is flagged together with the packet that shows the break.

Top module: `p7_stream_decoder`

## Requirements
- R1: After reset, all outputs are 0 and the decoder is searching. While searching, bytes with bit 7 clear are discarded and produce no pulse. The first byte with bit 7 set produces no output and makes the next accepted byte byte 1 of a packet.
- R2: When locked, bytes 1 to 10 must have bit 7 clear and byte 11 must have bit 7 set. Once byte 11 is accepted, `out_valid` is high for exactly the following cycle.
- R3: `counter` equals bits 6:1 of byte 1. `aux` is bit 0 of byte 1 (as aux bit 7) followed by bits 6:0 of byte 2 (as aux bits 6:0).
- R4: For pair j (0..2), the low 7 bits are taken from bits 6:0 of two bytes. Sample 2j takes them from byte 3+3j and sample 2j+1 from byte 4+3j. The high 3 bits are taken from byte 5+3j: bits 6:4 go to sample 2j and bits 2:0 go to sample 2j+1. Sample k occupies `samples[10k+9:10k]`.
- R5: `format_error` is high together with `out_valid` when bit 3 of byte 5, 8 or 11 is 1. The samples are still delivered.
- R6: If a byte with bit 7 set arrives at positions 1 to 10 while locked, the partial packet is dropped. `sync_error` is high for the following cycle, no `out_valid` is given, and the next byte is treated as byte 1.
- R7: If byte 11 arrives with bit 7 clear, the packet is dropped and `sync_error` is high for the following cycle. The decoder then searches again as in R1.
- R8: `counter_gap` is high together with `out_valid` when a packet was already delivered since reset and the new counter differs from the previous delivered counter plus one, modulo 64. It stays low on the first packet after reset.
- R9: Cycles with `in_valid` low are ignored whatever `in_byte` holds. The data outputs hold their last delivered values, and the pulses and flags stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | `in_byte` carries a received byte this cycle |
| in_byte | input | 8 | Received byte |
| out_valid | output | 1 | One-cycle pulse: a decoded packet is on the outputs |
| samples | output | 60 | Six 10-bit samples, sample 0 in the low bits |
| counter | output | 6 | Packet counter of the last delivered packet |
| aux | output | 8 | Auxiliary byte of the last delivered packet |
| format_error | output | 1 | Reserved shared-byte bit was set (with `out_valid`) |
| counter_gap | output | 1 | Counter sequence broken (with `out_valid`) |
| sync_error | output | 1 | One-cycle pulse: a packet was dropped for a marker fault |

## Verification
The embedded properties assume that `in_byte` matters only in cycles where `in_valid` is high, and that at most one byte arrives per clock. They check nothing about the stream's content beyond what the decoder itself decides. The stimulus drives random values on `in_byte` during every idle cycle, so that an ignored byte is really exercised. It inserts random idle runs between bytes and delivers malformed packets only as whole, deliberately truncated or marker-corrupted sequences. This keeps every marker fault at a position whose expected outcome follows from R6 and R7.

// File: rtl/p7dec_pkg.sv
package p7dec_pkg;

    // Framer lock state
    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_LOCK = 1'b1
    } frm_state_e;

    // Bytes in one packet for a given channel count (channels travel in pairs)
    function automatic int unsigned pkt_bytes(input int unsigned num_ch);
        return 2 + 3 * (num_ch / 2);
    endfunction

endpackage

// File: rtl/p7_framer.sv
module p7_framer
    import p7dec_pkg::*;
#(
    parameter int unsigned PKT_LEN = 11,
    parameter int unsigned POS_W   = $clog2(PKT_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_marker,
    output logic             take,
    output logic [POS_W-1:0] pos,
    output logic             done,
    output logic             sync_err
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(PKT_LEN - 1);

    typedef struct packed {
        frm_state_e       state;
        logic [POS_W-1:0] pos;
    } frm_t;

    frm_t frm_d, frm_q;

    always_comb begin
        frm_d    = frm_q;
        take     = 1'b0;
        done     = 1'b0;
        sync_err = 1'b0;
        if (in_valid) begin
            case (frm_q.state)
                ST_HUNT: begin
                    if (in_marker) begin
                        frm_d.state = ST_LOCK;
                        frm_d.pos   = '0;
                    end
                end
                default: begin
                    if (in_marker) begin
                        if (frm_q.pos == LAST_POS) begin
                            done = 1'b1;
                        end else begin
                            sync_err = 1'b1;
                        end
                        frm_d.pos = '0;
                    end else if (frm_q.pos == LAST_POS) begin
                        sync_err    = 1'b1;
                        frm_d.state = ST_HUNT;
                        frm_d.pos   = '0;
                    end else begin
                        take      = 1'b1;
                        frm_d.pos = frm_q.pos + 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frm_q <= '{state: ST_HUNT, pos: '0};
        end else begin
            frm_q <= frm_d;
        end
    end

    assign pos = frm_q.pos;

    // R2
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_q.pos <= LAST_POS);

    // R1
    hunt_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_q.state == ST_HUNT) |-> (!done && !take && !sync_err));

    // R6
    err_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |=> (frm_q.pos == '0));

    // R7
    lost_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_q.state == ST_LOCK && in_valid && !in_marker && frm_q.pos == LAST_POS)
        |=> (frm_q.state == ST_HUNT));

endmodule

// File: rtl/p7_assembler.sv
module p7_assembler #(
    parameter int unsigned NUM_CH  = 6,
    parameter int unsigned SMP_W   = 10,
    parameter int unsigned LO_W    = 7,
    parameter int unsigned CNT_W   = 6,
    parameter int unsigned PKT_LEN = 11,
    parameter int unsigned POS_W   = $clog2(PKT_LEN)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    take,
    input  logic [POS_W-1:0]        pos,
    input  logic [6:0]              payload,
    output logic [NUM_CH*SMP_W-1:0] samples,
    output logic [CNT_W-1:0]        counter,
    output logic [7:0]              aux,
    output logic                    fmt_err
);

    localparam int unsigned HELD  = PKT_LEN - 1;
    localparam int unsigned PAIRS = NUM_CH / 2;
    localparam int unsigned HI_W  = SMP_W - LO_W;

    typedef struct packed {
        logic [HELD-1:0][6:0] b;
    } hold_t;

    hold_t hold_d, hold_q;
    logic [PKT_LEN-1:0][6:0] view;
    logic [PAIRS-1:0]        rsv_bits;

    always_comb begin
        hold_d = hold_q;
        for (int k = 0; k < HELD; k++) begin
            if (take && pos == POS_W'(k)) begin
                hold_d.b[k] = payload;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    // Complete packet view: stored bytes plus the terminal byte now arriving
    always_comb begin
        view[HELD-1:0] = hold_q.b;
        view[HELD]     = payload;
    end

    assign counter = view[0][6:1];
    assign aux     = {view[0][0], view[1]};

    for (genvar j = 0; j < PAIRS; j++) begin : g_pair
        localparam int unsigned LO_A = 2 + 3 * j;
        localparam int unsigned LO_B = 3 + 3 * j;
        localparam int unsigned SHR  = 4 + 3 * j;
        assign samples[(2*j)*SMP_W +: SMP_W] =
            {view[SHR][6 -: HI_W], view[LO_A][LO_W-1:0]};
        assign samples[(2*j+1)*SMP_W +: SMP_W] =
            {view[SHR][HI_W-1:0], view[LO_B][LO_W-1:0]};
        assign rsv_bits[j] = view[SHR][3];
    end

    assign fmt_err = |rsv_bits;

    // R4
    store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (hold_q.b[$past(pos)] == $past(payload)));

endmodule

// File: rtl/p7_seq_check.sv
module p7_seq_check #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done,
    input  logic [CNT_W-1:0] cnt,
    output logic             gap
);

    typedef struct packed {
        logic             seen;
        logic [CNT_W-1:0] prev;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        gap   = 1'b0;
        if (done) begin
            gap        = seq_q.seen && (cnt != seq_q.prev + 1'b1);
            seq_d.seen = 1'b1;
            seq_d.prev = cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    // R8
    first_no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_q.seen |-> !gap);

endmodule

// File: rtl/p7_stream_decoder.sv
module p7_stream_decoder
    import p7dec_pkg::*;
#(
    parameter int unsigned NUM_CH = 6,
    parameter int unsigned SMP_W  = 10,
    parameter int unsigned LO_W   = 7,
    parameter int unsigned CNT_W  = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [7:0]              in_byte,
    output logic                    out_valid,
    output logic [NUM_CH*SMP_W-1:0] samples,
    output logic [CNT_W-1:0]        counter,
    output logic [7:0]              aux,
    output logic                    format_error,
    output logic                    counter_gap,
    output logic                    sync_error
);

    localparam int unsigned PKT_LEN = pkt_bytes(NUM_CH);
    localparam int unsigned POS_W   = $clog2(PKT_LEN);
    localparam int unsigned OUT_W   = NUM_CH * SMP_W;

    typedef struct packed {
        logic             valid;
        logic [OUT_W-1:0] smp;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       aux;
        logic             fmt;
        logic             gap;
        logic             serr;
    } out_t;

    logic             take, done, serr;
    logic [POS_W-1:0] pos;
    logic [OUT_W-1:0] asm_smp;
    logic [CNT_W-1:0] asm_cnt;
    logic [7:0]       asm_aux;
    logic             asm_fmt, gap;

    out_t out_d, out_q;

    p7_framer #(
        .PKT_LEN (PKT_LEN),
        .POS_W   (POS_W)
    ) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_marker (in_byte[7]),
        .take      (take),
        .pos       (pos),
        .done      (done),
        .sync_err  (serr)
    );

    p7_assembler #(
        .NUM_CH  (NUM_CH),
        .SMP_W   (SMP_W),
        .LO_W    (LO_W),
        .CNT_W   (CNT_W),
        .PKT_LEN (PKT_LEN),
        .POS_W   (POS_W)
    ) u_assembler (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .pos     (pos),
        .payload (in_byte[6:0]),
        .samples (asm_smp),
        .counter (asm_cnt),
        .aux     (asm_aux),
        .fmt_err (asm_fmt)
    );

    p7_seq_check #(
        .CNT_W (CNT_W)
    ) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (done),
        .cnt   (asm_cnt),
        .gap   (gap)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = done;
        out_d.serr  = serr;
        out_d.fmt   = 1'b0;
        out_d.gap   = 1'b0;
        if (done) begin
            out_d.smp = asm_smp;
            out_d.cnt = asm_cnt;
            out_d.aux = asm_aux;
            out_d.fmt = asm_fmt;
            out_d.gap = gap;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid    = out_q.valid;
    assign samples      = out_q.smp;
    assign counter      = out_q.cnt;
    assign aux          = out_q.aux;
    assign format_error = out_q.fmt;
    assign counter_gap  = out_q.gap;
    assign sync_error   = out_q.serr;

    // R2
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R6
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_valid, sync_error}));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !sync_error && $stable(samples) && $stable(aux)));

    // R5
    fmt_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        format_error |-> out_valid);

    // R8
    gap_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        counter_gap |-> out_valid);

endmodule

// File: tb/test_p7_stream_decoder.sv
`timescale 1ns/1ps
module test_p7_stream_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        out_valid, format_error, counter_gap, sync_error;
    logic [59:0] samples;
    logic [5:0]  counter;
    logic [7:0]  aux;

    int total = 0;
    int bad = 0;
    int n_val = 0;
    int n_err = 0;
    int exp_val = 0;
    int exp_err = 0;
    bit have_prev = 0;
    logic [5:0] prev_cnt = '0;
    bit finished = 0;

    always #4 clk = ~clk;

    p7_stream_decoder i_p7_stream_decoder (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_byte      (in_byte),
        .out_valid    (out_valid),
        .samples      (samples),
        .counter      (counter),
        .aux          (aux),
        .format_error (format_error),
        .counter_gap  (counter_gap),
        .sync_error   (sync_error)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) n_val++;
            if (sync_error) n_err++;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Packet bytes, byte i (0-based) at [8*i +: 8]
    function automatic logic [87:0] build(input logic [59:0] s, input logic [5:0] c,
                                          input logic [7:0] a, input logic [2:0] rsv);
        logic [87:0] p;
        p = '0;
        p[7:0]  = {1'b0, c, a[7]};
        p[15:8] = {1'b0, a[6:0]};
        for (int j = 0; j < 3; j++) begin
            logic [9:0] sa, sb;
            sa = s[(2*j)*10 +: 10];
            sb = s[(2*j+1)*10 +: 10];
            p[(2+3*j)*8 +: 8] = {1'b0, sa[6:0]};
            p[(3+3*j)*8 +: 8] = {1'b0, sb[6:0]};
            p[(4+3*j)*8 +: 8] = {(j == 2), sa[9:7], rsv[j], sb[9:7]};
        end
        return p;
    endfunction

    function automatic logic [59:0] rnd_samples();
        logic [59:0] s;
        s = {$urandom, $urandom};
        return s;
    endfunction

    // Called at a negedge; returns at the negedge after the consuming edge
    task automatic put_byte(input logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
        in_byte  = 8'($urandom);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            in_byte = 8'($urandom);
            @(negedge clk);
        end
    endtask

    task automatic send_bytes(input logic [87:0] p, input int n, input int maxgap);
        for (int i = 0; i < n; i++) begin
            put_byte(p[i*8 +: 8]);
            if (i < n - 1 && maxgap > 0) idle($urandom_range(maxgap, 0));
        end
    endtask

    task automatic send_pkt(input logic [59:0] s, input logic [5:0] c, input logic [7:0] a,
                            input logic [2:0] rsv, input int maxgap, input bit expect_out);
        logic exp_gap;
        send_bytes(build(s, c, a, rsv), 11, maxgap);
        if (expect_out) begin
            exp_gap = have_prev && (c != prev_cnt + 6'd1);
            chk("R2 out_valid", out_valid, 1);
            chk("R4 samples", samples, s);
            chk("R3 counter", counter, c);
            chk("R3 aux", aux, a);
            chk("R5 format_error", format_error, |rsv);
            chk("R8 counter_gap", counter_gap, exp_gap);
            chk("R2 no sync_error", sync_error, 0);
            have_prev = 1;
            prev_cnt  = c;
            exp_val++;
        end else begin
            chk("R7 no out_valid while searching", out_valid, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [59:0] s;
        logic [5:0]  c;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 reset out_valid", out_valid, 0);
        chk("R1 reset samples", samples, 0);
        chk("R1 reset counter", counter, 0);
        chk("R1 reset sync_error", sync_error, 0);

        // R1 junk with bit 7 clear is discarded, then a marker arms the decoder
        for (int i = 0; i < 5; i++) put_byte(8'($urandom) & 8'h7f);
        chk("R1 junk no output", {out_valid, sync_error}, 0);
        put_byte(8'h80);
        chk("R1 marker no output", {out_valid, sync_error}, 0);

        // R2 R3 R4 R8 all-ones samples, first packet never flags a gap
        send_pkt({6{10'h3ff}}, 6'd5, 8'hA5, 3'b000, 0, 1);
        idle(1);
        chk("R2 single-cycle pulse", out_valid, 0);
        chk("R9 samples held", samples, {6{10'h3ff}});

        // R4 distinct per-channel values, R9 idles inside the packet
        s = {10'h201, 10'h155, 10'h0aa, 10'h37f, 10'h080, 10'h07f};
        send_pkt(s, 6'd6, 8'h3C, 3'b000, 3, 1);

        // R5 reserved bit set in the last shared byte
        send_pkt(rnd_samples(), 6'd7, 8'h80, 3'b100, 0, 1);
        send_pkt(rnd_samples(), 6'd8, 8'h01, 3'b001, 0, 1);

        // R8 break in the sequence, then continuation and wrap
        send_pkt(rnd_samples(), 6'd20, 8'h11, 3'b000, 0, 1);
        send_pkt(rnd_samples(), 6'd21, 8'h22, 3'b000, 0, 1);
        send_pkt(rnd_samples(), 6'd63, 8'h33, 3'b000, 0, 1);
        send_pkt(rnd_samples(), 6'd0, 8'h44, 3'b000, 0, 1);

        // R6 marker at position 5: packet dropped, alignment kept
        send_bytes(build(rnd_samples(), 6'd1, 8'h55, 3'b000), 4, 0);
        put_byte(8'h85);
        chk("R6 sync_error pulse", sync_error, 1);
        chk("R6 no out_valid", out_valid, 0);
        exp_err++;
        idle(1);
        chk("R6 sync_error one cycle", sync_error, 0);
        send_pkt(rnd_samples(), 6'd1, 8'h66, 3'b000, 0, 1);

        // R7 byte 11 without marker: dropped, searching again
        s = rnd_samples();
        send_bytes(build(s, 6'd2, 8'h77, 3'b000), 10, 0);
        put_byte(8'h12);
        chk("R7 sync_error pulse", sync_error, 1);
        chk("R7 no out_valid", out_valid, 0);
        exp_err++;
        send_pkt(rnd_samples(), 6'd3, 8'h88, 3'b000, 0, 0);
        send_pkt(rnd_samples(), 6'd4, 8'h99, 3'b000, 0, 1);

        // R9 long idle with random bytes leaves outputs unchanged
        s = samples;
        c = counter;
        idle(20);
        chk("R9 samples hold", samples, s);
        chk("R9 counter hold", counter, c);
        chk("R9 no pulses", {out_valid, sync_error, format_error, counter_gap}, 0);

        // Random packets: occasional counter jumps, reserved bits, idle runs
        c = prev_cnt;
        for (int n = 0; n < 150; n++) begin
            logic [2:0] rsv;
            if ($urandom_range(9, 0) == 0) c = 6'($urandom);
            else c = c + 6'd1;
            rsv = ($urandom_range(9, 0) == 0) ? 3'($urandom) : 3'b000;
            send_pkt(rnd_samples(), c, 8'($urandom), rsv, $urandom_range(2, 0), 1);
            idle($urandom_range(3, 0));
        end

        idle(2);
        chk("R2 pulse count", n_val, exp_val);
        chk("R6 R7 sync_error count", n_err, exp_err);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule